// File: doc/BRIEF.md
# Chained Timer Cell Enable Controller

This block keeps the enable state of one cell in a daisy chain of capture, compare and timer cells. The enable is stored inverted, as a "hold-off" bit: 1 means the cell is armed but asleep, and 0 means it is live. Software reaches this bit through a register write port. A flag on that port marks a write as either a plain store or an atomic read-modify-write. For an atomic write, the port also carries the value of the hold-off bit that the operation read. The bit only changes when the atomic operation really flips it, so stale write-backs are harmless.

An armed cell also wakes when its lower-indexed neighbour puts a 1 on either of the two link lines. This lets software arm several cells and have them come alive one after another, or together. Local capture or compare events arrive as strobes. A live, active cell turns each event into an event-output pulse and a link command for the next cell. Two configurations make the cell inactive while its link keeps forwarding traffic: capture with no edge selected, and compare with no select level. A link option can forward the incoming lines without a register stage, so two cells wake in the same cycle.

The enable logic is a two-state machine. In `ST_ARMED` the cell is asleep; in `ST_LIVE` it is enabled. There are four transitions:
- `ST_ARMED` to `ST_LIVE` on a write that clears the hold-off bit (T_WR_ENABLE).
- `ST_ARMED` to `ST_LIVE` on any write in timer mode (T_TIMER_WAKE).
- `ST_ARMED` to `ST_LIVE` on link activity with no write in that cycle (T_LINK_WAKE).
- `ST_LIVE` to `ST_ARMED` on a capture or compare write that sets the hold-off bit (T_WR_DISARM).

Top module: `chain_cell_enable`

## Requirements
- R1: After reset the cell is in `ST_ARMED` (`cell_en`=0). The configuration is capture mode with every select bit 0, so `link_out` and `evt_out` are 0.
- R2: A plain write (`wr_rmw`=0) with capture mode (`wr_mode`=2'b00) or compare mode (2'b01) puts `cell_en` at the negation of `wr_eoa` from the next cycle.
- R3: An atomic write (`wr_rmw`=1) in capture or compare mode acts only when `wr_eoa` differs from `wr_eoa_seen`. When it acts, it enables on `wr_eoa`=0 and disables on `wr_eoa`=1. When the two are equal, `cell_en` keeps its value.
- R4: Any write with timer mode (`wr_mode[1]`=1) enables the cell from the next cycle, whatever `wr_rmw`, `wr_eoa` and `wr_eoa_seen` are.
- R5: While `cell_en` is 0, `local_evt` has no effect: no `evt_out` pulse and no link command.
- R6: While `cell_en` is 0 and no write is presented, a 1 on any bit of `link_in` enables the cell from the next cycle.
- R7: When a write and link activity arrive in the same cycle, the write alone decides the next enable state.
- R8: Capture mode with `wr_edge_sel`=3'b000 makes the cell inactive. `evt_out` is held at 0 and events send no link command, but `link_in` is still forwarded.
- R9: Compare mode with `wr_lvl_sel`=2'b00 makes the cell inactive. `evt_out` follows `evt_in` in the same cycle, events send no link command, and `link_in` is still forwarded.
- R10: `link_out` carries the `link_in` value of the previous cycle, ORed with any link command.
- R11: A local event on a live, active cell gives a one-cycle `evt_out` pulse in the following cycle. In that same cycle, `link_out` carries the low two bits of `wr_link_mode` (bits [1:0]); when those are 00, no command is sent.
- R12: With bit 2 of `wr_link_mode` set, `link_out` also carries the current `link_in` in the same cycle. A following armed cell therefore wakes in the same cycle as this one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_rmw | input | 1 | 1 = atomic read-modify-write, 0 = plain write |
| wr_mode | input | 2 | Mode: 00 capture, 01 compare, 1x timer |
| wr_edge_sel | input | 3 | Capture edge/level select bits |
| wr_lvl_sel | input | 2 | Compare select-level bits |
| wr_link_mode | input | LINK_W+1 | Link command bits [1:0], immediate-pass bit [2] |
| wr_eoa | input | 1 | Hold-off bit written (1 = armed/disabled) |
| wr_eoa_seen | input | 1 | Hold-off value read by the atomic operation |
| local_evt | input | 1 | Local capture/compare event strobe |
| evt_in | input | 1 | Event input, passed through in inactive compare mode |
| link_in | input | LINK_W | Link lines from the preceding cell |
| cell_en | output | 1 | Cell enabled for local events |
| link_out | output | LINK_W | Link lines to the following cell |
| evt_out | output | 1 | Event output |

## Verification
The enable path is exercised with three kinds of input pattern:
- Plain and atomic writes, including every pairing of written and read-back hold-off values. This separates a real bit flip from a stale write-back.
- Timer-mode writes carrying a hold-off value of 1. These show that timer mode overrides the bit.
- A write coinciding with link activity, which shows which one wins.

Three cells are chained and a single event in the first one is traced down the chain. With registered forwarding, the downstream cells must wake in successive cycles. With immediate pass, two of them must wake in the same cycle. The two inactive configurations each receive an event together with link traffic. This shows that the events are suppressed while forwarding continues.

// File: rtl/chain_cell_pkg.sv
package chain_cell_pkg;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_LIVE  = 1'b1
    } cell_state_e;

    localparam int MODE_W = 2;
    localparam int EDGE_W = 3;
    localparam int LVL_W  = 2;

    localparam logic [MODE_W-1:0] MODE_CAP = 2'b00;
    localparam logic [MODE_W-1:0] MODE_CMP = 2'b01;

    function automatic logic mode_is_timer(input logic [MODE_W-1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/cce_cfg_reg.sv
module cce_cfg_reg
    import chain_cell_pkg::*;
#(
    parameter int LINK_W = 2,
    localparam int OCM_W = LINK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [EDGE_W-1:0] wr_edge_sel,
    input  logic [LVL_W-1:0]  wr_lvl_sel,
    input  logic [OCM_W-1:0]  wr_link_mode,
    output logic [OCM_W-1:0]  link_mode_q,
    output logic              deact_cap,
    output logic              deact_cmp
);

    logic [MODE_W-1:0] mode_q;
    logic [EDGE_W-1:0] edge_q;
    logic [LVL_W-1:0]  lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= MODE_CAP;
            edge_q      <= '0;
            lvl_q       <= '0;
            link_mode_q <= '0;
        end else if (wr_en) begin
            mode_q      <= wr_mode;
            edge_q      <= wr_edge_sel;
            lvl_q       <= wr_lvl_sel;
            link_mode_q <= wr_link_mode;
        end
    end

    always_comb begin
        deact_cap = (mode_q == MODE_CAP) && (edge_q == '0);
        deact_cmp = (mode_q == MODE_CMP) && (lvl_q == '0);
    end

endmodule

// File: rtl/cce_enable_fsm.sv
module cce_enable_fsm
    import chain_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_rmw,
    input  logic wr_timer,
    input  logic wr_eoa,
    input  logic wr_eoa_seen,
    input  logic link_wake,
    output logic cell_en
);

    cell_state_e state_q, state_d;
    logic        eoa_apply;

    // Protected bit: an atomic write only counts when it flips the bit it read.
    assign eoa_apply = !wr_rmw || (wr_eoa != wr_eoa_seen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (wr_en) begin
                    if (wr_timer)                  state_d = ST_LIVE;  // T_TIMER_WAKE
                    else if (eoa_apply && !wr_eoa) state_d = ST_LIVE;  // T_WR_ENABLE
                end else if (link_wake) begin
                    state_d = ST_LIVE;                                 // T_LINK_WAKE
                end
            end
            ST_LIVE: begin
                if (wr_en && !wr_timer && eoa_apply && wr_eoa)
                    state_d = ST_ARMED;                                // T_WR_DISARM
            end
        endcase
    end

    always_comb begin
        cell_en = (state_q == ST_LIVE);
    end

endmodule

// File: rtl/cce_link_stage.sv
module cce_link_stage #(
    parameter int LINK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] link_in,
    input  logic [LINK_W-1:0] cmd_bits,
    input  logic              imm_pass,
    input  logic              hit,
    input  logic              deact_cap,
    input  logic              deact_cmp,
    input  logic              evt_in,
    output logic [LINK_W-1:0] link_out,
    output logic              evt_out
);

    logic evt_q;

    for (genvar i = 0; i < LINK_W; i++) begin : g_lane
        logic lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= 1'b0;
            else        lane_q <= link_in[i] | (hit & cmd_bits[i]);
        end
        assign link_out[i] = lane_q | (imm_pass & link_in[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= hit;
    end

    always_comb begin
        if (deact_cap)      evt_out = 1'b0;
        else if (deact_cmp) evt_out = evt_in;
        else                evt_out = evt_q;
    end

endmodule

// File: rtl/chain_cell_enable.sv
module chain_cell_enable
    import chain_cell_pkg::*;
#(
    parameter int LINK_W = 2,
    localparam int OCM_W = LINK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_rmw,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [EDGE_W-1:0] wr_edge_sel,
    input  logic [LVL_W-1:0]  wr_lvl_sel,
    input  logic [OCM_W-1:0]  wr_link_mode,
    input  logic              wr_eoa,
    input  logic              wr_eoa_seen,
    input  logic              local_evt,
    input  logic              evt_in,
    input  logic [LINK_W-1:0] link_in,
    output logic              cell_en,
    output logic [LINK_W-1:0] link_out,
    output logic              evt_out
);

    logic [OCM_W-1:0] link_mode_q;
    logic             deact_cap;
    logic             deact_cmp;
    logic             imm_pass;
    logic             local_hit;

    cce_cfg_reg #(.LINK_W(LINK_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_mode      (wr_mode),
        .wr_edge_sel  (wr_edge_sel),
        .wr_lvl_sel   (wr_lvl_sel),
        .wr_link_mode (wr_link_mode),
        .link_mode_q  (link_mode_q),
        .deact_cap    (deact_cap),
        .deact_cmp    (deact_cmp)
    );

    cce_enable_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_rmw      (wr_rmw),
        .wr_timer    (mode_is_timer(wr_mode)),
        .wr_eoa      (wr_eoa),
        .wr_eoa_seen (wr_eoa_seen),
        .link_wake   (|link_in),
        .cell_en     (cell_en)
    );

    assign imm_pass  = link_mode_q[LINK_W];
    assign local_hit = local_evt & cell_en & ~deact_cap & ~deact_cmp;

    cce_link_stage #(.LINK_W(LINK_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_in   (link_in),
        .cmd_bits  (link_mode_q[LINK_W-1:0]),
        .imm_pass  (imm_pass),
        .hit       (local_hit),
        .deact_cap (deact_cap),
        .deact_cmp (deact_cmp),
        .evt_in    (evt_in),
        .link_out  (link_out),
        .evt_out   (evt_out)
    );

endmodule

// File: rtl/chain_cell_enable_chk.sv
module chain_cell_enable_chk #(
    parameter int LINK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_rmw,
    input logic [1:0]        wr_mode,
    input logic              wr_eoa,
    input logic              wr_eoa_seen,
    input logic [LINK_W-1:0] link_in,
    input logic [LINK_W-1:0] link_out,
    input logic              cell_en,
    input logic              evt_in,
    input logic              evt_out,
    input logic              deact_cap,
    input logic              deact_cmp,
    input logic              imm_pass
);

    a_r2_plain_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_rmw && !wr_mode[1] && !wr_eoa |=> cell_en);

    a_r3_rmw_stale_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_rmw && !wr_mode[1] && (wr_eoa == wr_eoa_seen) |=> cell_en == $past(cell_en));

    a_r4_timer_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_mode[1] |=> cell_en);

    a_r5_armed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_en |=> deact_cmp || !evt_out);

    a_r6_link_wake: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !cell_en && (|link_in) |=> cell_en);

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_rmw && !wr_mode[1] && wr_eoa |=> !cell_en);

    a_r8_cap_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        deact_cap |-> !evt_out);

    a_r9_cmp_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        deact_cmp |-> evt_out == evt_in);

    a_r10_link_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (|link_in) |=> (link_out & $past(link_in)) == $past(link_in));

    a_r12_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        imm_pass |-> (link_out & link_in) == link_in);

endmodule

bind chain_cell_enable chain_cell_enable_chk #(.LINK_W(LINK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_rmw      (wr_rmw),
    .wr_mode     (wr_mode),
    .wr_eoa      (wr_eoa),
    .wr_eoa_seen (wr_eoa_seen),
    .link_in     (link_in),
    .link_out    (link_out),
    .cell_en     (cell_en),
    .evt_in      (evt_in),
    .evt_out     (evt_out),
    .deact_cap   (deact_cap),
    .deact_cmp   (deact_cmp),
    .imm_pass    (imm_pass)
);

// File: tb/chain_cell_enable_test.sv
`timescale 1ns/1ps
module chain_cell_enable_test;

    localparam int N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]       wr_en = '0;
    logic [N-1:0]       wr_rmw = '0;
    logic [N-1:0][1:0]  wr_mode = '0;
    logic [N-1:0][2:0]  wr_edge = '0;
    logic [N-1:0][1:0]  wr_lvl = '0;
    logic [N-1:0][2:0]  wr_ocm = '0;
    logic [N-1:0]       wr_eoa = '0;
    logic [N-1:0]       wr_seen = '0;
    logic [N-1:0]       levt = '0;
    logic               evt_in0 = 1'b0;
    logic [1:0]         tb_link = '0;
    logic [N-1:0]       en;
    logic [N-1:0]       eo;
    logic [N-1:0][1:0]  lo;

    int checks = 0;
    int fails  = 0;

    chain_cell_enable uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[0]), .wr_rmw(wr_rmw[0]),
        .wr_mode(wr_mode[0]), .wr_edge_sel(wr_edge[0]), .wr_lvl_sel(wr_lvl[0]),
        .wr_link_mode(wr_ocm[0]), .wr_eoa(wr_eoa[0]), .wr_eoa_seen(wr_seen[0]),
        .local_evt(levt[0]), .evt_in(evt_in0), .link_in(tb_link),
        .cell_en(en[0]), .link_out(lo[0]), .evt_out(eo[0]));

    chain_cell_enable uut_n1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[1]), .wr_rmw(wr_rmw[1]),
        .wr_mode(wr_mode[1]), .wr_edge_sel(wr_edge[1]), .wr_lvl_sel(wr_lvl[1]),
        .wr_link_mode(wr_ocm[1]), .wr_eoa(wr_eoa[1]), .wr_eoa_seen(wr_seen[1]),
        .local_evt(levt[1]), .evt_in(1'b0), .link_in(lo[0]),
        .cell_en(en[1]), .link_out(lo[1]), .evt_out(eo[1]));

    chain_cell_enable uut_n2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[2]), .wr_rmw(wr_rmw[2]),
        .wr_mode(wr_mode[2]), .wr_edge_sel(wr_edge[2]), .wr_lvl_sel(wr_lvl[2]),
        .wr_link_mode(wr_ocm[2]), .wr_eoa(wr_eoa[2]), .wr_eoa_seen(wr_seen[2]),
        .local_evt(levt[2]), .evt_in(1'b0), .link_in(lo[1]),
        .cell_en(en[2]), .link_out(lo[2]), .evt_out(eo[2]));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_wr(input int c, input logic rmw, input logic [1:0] mode,
                          input logic [2:0] edg, input logic [1:0] lvl,
                          input logic [2:0] ocm, input logic eoa, input logic seen);
        wr_rmw[c] = rmw; wr_mode[c] = mode; wr_edge[c] = edg; wr_lvl[c] = lvl;
        wr_ocm[c] = ocm; wr_eoa[c] = eoa; wr_seen[c] = seen; wr_en[c] = 1'b1;
    endtask

    task automatic do_wr(input int c, input logic rmw, input logic [1:0] mode,
                         input logic [2:0] edg, input logic [1:0] lvl,
                         input logic [2:0] ocm, input logic eoa, input logic seen);
        set_wr(c, rmw, mode, edg, lvl, ocm, eoa, seen);
        tick();
        wr_en[c] = 1'b0;
    endtask

    task automatic pulse_evt(input int c);
        levt[c] = 1'b1;
        tick();
        levt[c] = 1'b0;
    endtask

    task automatic rearm_tail(input logic [2:0] ocm1);
        tick(); tick(); tick();
        do_wr(1, 1'b0, 2'b00, 3'b001, 2'b00, ocm1, 1'b1, 1'b0);
        do_wr(2, 1'b0, 2'b00, 3'b001, 2'b00, 3'b000, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 cell_en", {5'd0, en}, 8'h00);
        check("R1 link_out", {2'd0, lo}, 8'h00);
        check("R1 evt_out", {5'd0, eo}, 8'h00);
    endtask

    task automatic t_plain();
        do_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b000, 1'b0, 1'b0);
        check("R2 plain clear enables", en[0], 1'b1);
        do_wr(0, 1'b0, 2'b01, 3'b000, 2'b01, 3'b000, 1'b1, 1'b0);
        check("R2 plain set disables", en[0], 1'b0);
    endtask

    task automatic t_rmw();
        do_wr(0, 1'b1, 2'b00, 3'b001, 2'b00, 3'b000, 1'b0, 1'b0);
        check("R3 stale 0->0 no enable", en[0], 1'b0);
        do_wr(0, 1'b1, 2'b00, 3'b001, 2'b00, 3'b000, 1'b0, 1'b1);
        check("R3 flip 1->0 enables", en[0], 1'b1);
        do_wr(0, 1'b1, 2'b01, 3'b000, 2'b01, 3'b000, 1'b1, 1'b1);
        check("R3 stale 1->1 no disable", en[0], 1'b1);
        do_wr(0, 1'b1, 2'b01, 3'b000, 2'b01, 3'b000, 1'b1, 1'b0);
        check("R3 flip 0->1 disables", en[0], 1'b0);
    endtask

    task automatic t_timer();
        do_wr(0, 1'b1, 2'b10, 3'b000, 2'b00, 3'b000, 1'b1, 1'b1);
        check("R4 rmw timer write enables", en[0], 1'b1);
        do_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b000, 1'b1, 1'b0);
        check("R4 setup disarm", en[0], 1'b0);
        do_wr(0, 1'b0, 2'b11, 3'b000, 2'b00, 3'b000, 1'b1, 1'b0);
        check("R4 plain timer write eoa=1 enables", en[0], 1'b1);
    endtask

    task automatic t_armed_ignores();
        do_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b011, 1'b1, 1'b0);
        pulse_evt(0);
        check("R5 armed evt_out", eo[0], 1'b0);
        check("R5 armed link_out", {6'd0, lo[0]}, 8'h00);
        check("R5 armed stays disabled", en[0], 1'b0);
    endtask

    task automatic t_event_cmd();
        do_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b011, 1'b0, 1'b0);
        check("R11 before event link_out", {6'd0, lo[0]}, 8'h00);
        pulse_evt(0);
        check("R11 command on link", {6'd0, lo[0]}, 8'h03);
        check("R11 evt_out pulse", eo[0], 1'b1);
        tick();
        check("R11 command one cycle", {6'd0, lo[0]}, 8'h00);
        check("R11 pulse one cycle", eo[0], 1'b0);
        do_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b000, 1'b0, 1'b0);
        pulse_evt(0);
        check("R11 ocm 00 no command", {6'd0, lo[0]}, 8'h00);
        check("R11 ocm 00 evt_out", eo[0], 1'b1);
    endtask

    task automatic t_chain_seq();
        rearm_tail(3'b000);
        do_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b001, 1'b0, 1'b0);
        pulse_evt(0);
        check("R6 n1 still armed", en[1], 1'b0);
        tick();
        check("R6 n1 woken by link", en[1], 1'b1);
        check("R10 n2 not yet", en[2], 1'b0);
        check("R10 n1 forwards one cycle later", {6'd0, lo[1]}, 8'h01);
        tick();
        check("R10 n2 woken next cycle", en[2], 1'b1);
    endtask

    task automatic t_chain_imm();
        rearm_tail(3'b100);
        pulse_evt(0);
        check("R12 n1 armed", en[1], 1'b0);
        check("R12 n2 armed", en[2], 1'b0);
        check("R12 n1 forwards same cycle", {6'd0, lo[1]}, 8'h01);
        tick();
        check("R12 n1 woken", en[1], 1'b1);
        check("R12 n2 woken together", en[2], 1'b1);
    endtask

    task automatic t_write_wins();
        do_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b000, 1'b1, 1'b0);
        set_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b000, 1'b1, 1'b0);
        tb_link = 2'b01;
        tick();
        wr_en[0] = 1'b0;
        check("R7 write beats link", en[0], 1'b0);
        tick();
        tb_link = 2'b00;
        check("R6 link wakes after write", en[0], 1'b1);
    endtask

    task automatic t_forward();
        do_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b000, 1'b0, 1'b0);
        tick();
        tb_link = 2'b10;
        #1;
        check("R10 not combinational", {6'd0, lo[0]}, 8'h00);
        tick();
        tb_link = 2'b00;
        check("R10 registered forward", {6'd0, lo[0]}, 8'h02);
        do_wr(0, 1'b0, 2'b00, 3'b001, 2'b00, 3'b100, 1'b0, 1'b0);
        tick();
        tb_link = 2'b10;
        #1;
        check("R12 immediate on uut", {6'd0, lo[0]}, 8'h02);
        tick();
        tb_link = 2'b00;
    endtask

    task automatic t_cap_inactive();
        do_wr(0, 1'b0, 2'b00, 3'b000, 2'b00, 3'b011, 1'b0, 1'b0);
        tick();
        levt[0] = 1'b1;
        tb_link = 2'b10;
        tick();
        levt[0] = 1'b0;
        tb_link = 2'b00;
        check("R8 evt_out held low", eo[0], 1'b0);
        check("R8 forward, no command", {6'd0, lo[0]}, 8'h02);
    endtask

    task automatic t_cmp_inactive();
        do_wr(0, 1'b0, 2'b01, 3'b000, 2'b00, 3'b011, 1'b0, 1'b0);
        tick();
        evt_in0 = 1'b1;
        #1;
        check("R9 evt_in passes high", eo[0], 1'b1);
        evt_in0 = 1'b0;
        #1;
        check("R9 evt_in passes low", eo[0], 1'b0);
        levt[0] = 1'b1;
        tb_link = 2'b01;
        tick();
        levt[0] = 1'b0;
        tb_link = 2'b00;
        check("R9 forward, no command", {6'd0, lo[0]}, 8'h01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_plain();
        t_rmw();
        t_timer();
        t_armed_ignores();
        t_event_cmd();
        t_chain_seq();
        t_chain_imm();
        t_write_wins();
        t_forward();
        t_cap_inactive();
        t_cmp_inactive();
        tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule